// File: doc/BRIEF.md
# Character LCD Power-Up and Text Sequencer

This block drives an 8-bit parallel character display through its startup without any software help. After reset it holds the enable strobe low for a power-on interval. It then issues four setup commands, followed by four text characters. Each byte goes out on a data bus with a register-select line, and the display latches it on a timed enable pulse.

Each bus action is one state of a small state machine. A shared down-counter sets every interval: the power-on wait, the enable-high width, and the settle time after each byte. The settle time is longer after the screen-clear command. All intervals are given in nanoseconds and converted to clock cycles from the clock frequency parameter when the design is elaborated. Once the last character has been written, a completion flag rises and the bus stays idle until the next reset.

Top module: `lcd_init_writer`

## Requirements
- R1: While rst_ni is low, en_o, done_o, rs_o and data_o are all 0. After reset is released, en_o stays low for exactly ceil(PWRUP_NS·CLK_HZ/1e9) cycles before the first enable pulse begins.
- R2: The first four bytes are commands, sent with rs_o = 0, in the order 0x38, 0x01, 0x06, 0x0C.
- R3: The next four bytes are text, sent with rs_o = 1, in the order 0x53, 0x48, 0x52, 0x49.
- R4: rw_o is 0 in every cycle.
- R5: Every enable pulse is high for exactly ceil(EN_HIGH_NS·CLK_HZ/1e9) consecutive cycles, and never for fewer than 1.
- R6: data_o and rs_o carry the byte for at least one cycle before en_o rises. They stay unchanged while en_o is high and for at least one cycle after it falls.
- R7: Between two pulses, en_o is low for exactly the settle cycle count plus 2. After the 0x01 clear command, the clear cycle count is used in place of the settle count.
- R8: done_o rises settle+1 cycles after the last pulse ends. From then on done_o stays 1, en_o stays 0, and data_o (0x49) and rs_o (1) hold their values until reset.
- R9: A reset applied mid-sequence returns the block to the power-on wait and restarts the byte order from 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_o | output | 8 | Byte presented to the display |
| rs_o | output | 1 | Register select: 0 for a command, 1 for a character |
| rw_o | output | 1 | Read/write select, always write (0) |
| en_o | output | 1 | Latch strobe |
| done_o | output | 1 | Sequence complete |

## Verification
The bench counts the cycles of each strobe exactly. A counter that is off by one, or a pulse width rounded down instead of up, shows up as a wrong high count or a wrong low gap. The gap after the clear command is checked on its own, so a design that used the short settle time there would fail. Bytes are sampled one cycle before each rising edge and one cycle after each falling edge, which catches data that changes together with the strobe. The final test resets the block after a few bytes. A step index that survived reset would send the wrong first byte, and a power-on timer that was not reloaded would give a short power-on gap.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int unsigned NUM_STEPS = 8;
  localparam int unsigned IDX_W     = $clog2(NUM_STEPS);
  localparam int unsigned CLEAR_IDX = 1;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_SETUP,
    ST_EN_HI,
    ST_HOLD,
    ST_SETTLE,
    ST_DONE
  } seq_state_e;

  // ceil(ns * hz / 1e9), at least one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned hz);
    longint unsigned prod;
    prod = longint'(ns) * longint'(hz);
    prod = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (prod == 0) prod = 1;
    return 32'(prod);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // {rs, byte}
  function automatic logic [8:0] step_entry(logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return {1'b0, 8'h38};
      3'd1:    return {1'b0, 8'h01};
      3'd2:    return {1'b0, 8'h06};
      3'd3:    return {1'b0, 8'h0C};
      3'd4:    return {1'b1, 8'h53};
      3'd5:    return {1'b1, 8'h48};
      3'd6:    return {1'b1, 8'h52};
      default: return {1'b1, 8'h49};
    endcase
  endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
  import lcd_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o,
  output logic             is_char_o
);

  logic [8:0] entry;

  always_comb begin
    entry     = step_entry(idx_i);
    byte_o    = entry[7:0];
    is_char_o = entry[8];
  end

endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned EN_CYC     = 23,
  parameter int unsigned SETTLE_CYC = 2000,
  parameter int unsigned CLEAR_CYC  = 82000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic [IDX_W-1:0] fetch_idx_o,
  input  logic [7:0]       byte_i,
  input  logic             is_char_i,
  output logic [7:0]       data_o,
  output logic             rs_o,
  output logic             en_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] EN_LD  = CNT_W'(EN_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] CLR_LD = CNT_W'(CLEAR_CYC - 1);
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(NUM_STEPS - 1);
  localparam logic [IDX_W-1:0] CLR_IX = IDX_W'(CLEAR_IDX);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             take_byte;
  logic [7:0]       data_q;
  logic             rs_q;

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    take_byte  = 1'b0;
    case (st_q)
      ST_PWR: begin
        if (tmr_zero_i) begin
          st_d      = ST_SETUP;
          take_byte = 1'b1;
        end
      end
      ST_SETUP: begin
        st_d       = ST_EN_HI;
        tmr_load_o = 1'b1;
        tmr_val_o  = EN_LD;
      end
      ST_EN_HI: begin
        if (tmr_zero_i) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        st_d       = ST_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = (idx_q == CLR_IX) ? CLR_LD : SET_LD;
      end
      ST_SETTLE: begin
        if (tmr_zero_i) begin
          if (idx_q == LAST) begin
            st_d = ST_DONE;
          end else begin
            idx_d     = idx_q + 1'b1;
            st_d      = ST_SETUP;
            take_byte = 1'b1;
          end
        end
      end
      default: st_d = ST_DONE;
    endcase
  end

  assign fetch_idx_o = idx_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PWR;
      idx_q  <= '0;
      data_q <= '0;
      rs_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (take_byte) begin
        data_q <= byte_i;
        rs_q   <= is_char_i;
      end
    end
  end

  assign data_o = data_q;
  assign rs_o   = rs_q;
  assign en_o   = (st_q == ST_EN_HI);
  assign done_o = (st_q == ST_DONE);

endmodule

// File: rtl/lcd_init_writer.sv
module lcd_init_writer
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned EN_HIGH_NS = 450,
  parameter int unsigned PWRUP_NS   = 15_000_000,
  parameter int unsigned SETTLE_NS  = 40_000,
  parameter int unsigned CLEAR_NS   = 1_640_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [7:0] data_o,
  output logic       rs_o,
  output logic       rw_o,
  output logic       en_o,
  output logic       done_o
);

  localparam int unsigned EN_CYC     = ns_to_cyc(EN_HIGH_NS, CLK_HZ);
  localparam int unsigned PWR_CYC    = ns_to_cyc(PWRUP_NS, CLK_HZ);
  localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_HZ);
  localparam int unsigned CLEAR_CYC  = ns_to_cyc(CLEAR_NS, CLK_HZ);
  localparam int unsigned MAX_CYC    = max3(max3(EN_CYC, PWR_CYC, 1), SETTLE_CYC, CLEAR_CYC);
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [IDX_W-1:0] fetch_idx;
  logic [7:0]       rom_byte;
  logic             rom_char;

  lcd_seq_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PWR_CYC - 1)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  lcd_seq_rom u_rom (
    .idx_i    (fetch_idx),
    .byte_o   (rom_byte),
    .is_char_o(rom_char)
  );

  lcd_seq_fsm #(
    .CNT_W     (CNT_W),
    .EN_CYC    (EN_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .CLEAR_CYC (CLEAR_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .fetch_idx_o(fetch_idx),
    .byte_i     (rom_byte),
    .is_char_i  (rom_char),
    .data_o     (data_o),
    .rs_o       (rs_o),
    .en_o       (en_o),
    .done_o     (done_o)
  );

  assign rw_o = 1'b0;

endmodule

// File: rtl/lcd_init_writer_chk.sv
module lcd_init_writer_chk #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned EN_HIGH_NS = 450
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_o,
  input logic       rs_o,
  input logic       rw_o,
  input logic       en_o,
  input logic       done_o
);

  localparam int unsigned EN_CYC = lcd_seq_pkg::ns_to_cyc(EN_HIGH_NS, CLK_HZ);
  localparam int unsigned HW     = $clog2(EN_CYC + 2);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hi_cnt <= '0;
    else if (en_o) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  // R4
  rw_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rw_o == 1'b0);

  // R5
  en_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) |-> hi_cnt == HW'(EN_CYC));

  // R6
  en_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> $stable(data_o) && $stable(rs_o));

  // R6
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> $stable(data_o) && $stable(rs_o));

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !en_o && $stable(data_o) && $stable(rs_o));

  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && en_o));

endmodule

bind lcd_init_writer lcd_init_writer_chk #(
  .CLK_HZ    (CLK_HZ),
  .EN_HIGH_NS(EN_HIGH_NS)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .data_o(data_o),
  .rs_o  (rs_o),
  .rw_o  (rw_o),
  .en_o  (en_o),
  .done_o(done_o)
);

// File: tb/lcd_init_writer_tb.sv
`timescale 1ns/1ps
module lcd_init_writer_tb;

  localparam int CLK_PERIOD = 100;          // 10 MHz
  localparam int unsigned TB_HZ = 10_000_000;
  // expected cycle counts, ceil(ns / 100)
  localparam int EXP_EN  = 5;    // 450 ns
  localparam int EXP_PWR = 50;   // 5000 ns
  localparam int EXP_SET = 20;   // 2000 ns
  localparam int EXP_CLR = 60;   // 6000 ns

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_o;
  logic       rs_o, rw_o, en_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_byte [8] = '{8'h38, 8'h01, 8'h06, 8'h0C, 8'h53, 8'h48, 8'h52, 8'h49};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lcd_init_writer #(
    .CLK_HZ    (TB_HZ),
    .EN_HIGH_NS(450),
    .PWRUP_NS  (5000),
    .SETTLE_NS (2000),
    .CLEAR_NS  (6000)
  ) u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_o(data_o),
    .rs_o  (rs_o),
    .rw_o  (rw_o),
    .en_o  (en_o),
    .done_o(done_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk_i);
  endtask

  // Waits for one strobe; reports byte, rs, low samples before it and high samples
  task automatic grab_byte(output logic [7:0] d, output logic r, output int lows, output int highs);
    logic [7:0] pd;
    logic       pr;
    lows = 0; highs = 0; pd = '0; pr = 1'b0;
    sample();
    while (!en_o && lows < 5000) begin
      if (rw_o !== 1'b0) check(1'b0, "R4", "rw", int'(rw_o), 0);
      if (done_o !== 1'b0) check(1'b0, "R8", "done early", int'(done_o), 0);
      pd = data_o; pr = rs_o; lows++;
      sample();
    end
    d = data_o; r = rs_o;
    check(pd == d && pr == r, "R6", "setup byte", int'({pr, pd}), int'({r, d}));
    while (en_o && highs < 5000) begin
      if (data_o !== d || rs_o !== r)
        check(1'b0, "R6", "byte moved while en high", int'(data_o), int'(d));
      highs++;
      sample();
    end
    check(data_o == d && rs_o == r, "R6", "hold byte", int'({rs_o, data_o}), int'({r, d}));
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (3) sample();
    check(en_o == 1'b0,   "R1", "en in reset", int'(en_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(data_o == 8'h0 && rs_o == 1'b0, "R1", "bus in reset", int'({rs_o, data_o}), 0);
    check(rw_o == 1'b0,   "R4", "rw in reset", int'(rw_o), 0);
  endtask

  task automatic t_full_run();
    logic [7:0] d;
    logic r;
    int lows, highs, n;
    rst_ni = 1'b1;
    for (int k = 0; k < 8; k++) begin
      grab_byte(d, r, lows, highs);
      if (k < 4) begin
        check(d == exp_byte[k], "R2", $sformatf("command %0d", k), int'(d), int'(exp_byte[k]));
        check(r == 1'b0, "R2", "rs for command", int'(r), 0);
      end else begin
        check(d == exp_byte[k], "R3", $sformatf("char %0d", k), int'(d), int'(exp_byte[k]));
        check(r == 1'b1, "R3", "rs for char", int'(r), 1);
      end
      check(highs == EXP_EN, "R5", "en high cycles", highs, EXP_EN);
      if (k == 0)      check(lows == EXP_PWR, "R1", "power-on gap", lows, EXP_PWR);
      else if (k == 2) check(lows + 1 == EXP_CLR + 2, "R7", "gap after clear", lows + 1, EXP_CLR + 2);
      else             check(lows + 1 == EXP_SET + 2, "R7", "settle gap", lows + 1, EXP_SET + 2);
    end
    n = 0;
    while (!done_o && n < 5000) begin
      n++;
      sample();
    end
    check(n == EXP_SET + 1, "R8", "done delay", n, EXP_SET + 1);
  endtask

  task automatic t_idle();
    int bad;
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      sample();
      if (!(done_o && !en_o && data_o == 8'h49 && rs_o && !rw_o)) bad++;
    end
    check(bad == 0, "R8", "idle after done", bad, 0);
  endtask

  task automatic t_mid_reset();
    logic [7:0] d;
    logic r;
    int lows, highs;
    rst_ni = 1'b0;
    repeat (2) sample();
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) grab_byte(d, r, lows, highs);
    repeat (4) sample();
    rst_ni = 1'b0;
    #1;
    check(en_o == 1'b0 && done_o == 1'b0 && data_o == 8'h0, "R9", "outputs after mid reset",
          int'({done_o, en_o, data_o}), 0);
    repeat (2) sample();
    rst_ni = 1'b1;
    grab_byte(d, r, lows, highs);
    check(d == 8'h38 && r == 1'b0, "R9", "first byte after restart", int'(d), 8'h38);
    check(lows == EXP_PWR, "R9", "power-on gap after restart", lows, EXP_PWR);
    grab_byte(d, r, lows, highs);
    check(d == 8'h01, "R9", "second byte after restart", int'(d), 8'h01);
  endtask

  initial begin
    t_reset_state();
    t_full_run();
    t_idle();
    t_mid_reset();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule